// File: doc/BRIEF.md
# Interleaved Memory Block Fetch Controller

This block refills one cache block of four words from four one-word-wide memory banks. Word k of a block always sits in bank k, so the low bits of a word address pick the bank and the block address picks the row inside every bank. The storage of the banks is modelled inside the block as four small arrays. Their contents are set by reset to a fixed pattern, because writes are not part of this block.

A refill starts when a request is seen while the controller is idle. It spends one cycle presenting the block address to the banks, waits out the bank access latency, then returns the words on a one-word bus, one per cycle with a valid strobe and an index. A one-cycle done pulse follows. A parameter selects the bank timing. In the overlapped variant all four banks access at the same time, so a refill costs 1 + 15 + 4 = 20 cycles up to the last word. In the serialized variant one bank accesses at a time and each word goes out before the next access starts, so a refill costs 1 + 4×15 + 4 = 65 cycles.

Controller states: IDLE, ADDR (address cycle), ACCESS (bank latency running), XFER (one word on the bus), DONE (done pulse). Transitions:
- IDLE→ADDR on an accepted request.
- ADDR→ACCESS always.
- ACCESS→XFER when the bank latency expires.
- XFER→XFER to the next word (overlapped variant only).
- XFER→ACCESS to start the next bank (serialized variant only).
- XFER→DONE after the last word.
- DONE→IDLE always.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy_o`, `word_vld_o` and `done_o` are 0, and `word_idx_o` and `word_data_o` are 0.
- R2: A request is taken only at a clock edge where the controller is idle (`busy_o` = 0). `busy_o` is 1 from the cycle after that edge up to and including the done cycle. A request seen while busy is ignored and does not change the words returned.
- R3: With INTERLEAVE=1, let t = 0 be the first busy cycle. Word k is valid in cycle t = 1 + LAT + k, so with LAT=15 the last word is valid 20 cycles after acceptance.
- R4: With INTERLEAVE=0, word k is valid in cycle t = 1 + LAT + k·(LAT+1), so with LAT=15 the last word is valid 65 cycles after acceptance.
- R5: Words are returned in order k = 0, 1, 2, 3, with `word_idx_o` = k. Word k comes from bank k, row = block address, and its value is ((4·A + k) × 0x00010001) XOR 0xC3C30000, where A is the block address taken at acceptance.
- R6: `done_o` is high for exactly one cycle, the cycle right after the last word. In the cycle after that the controller is idle.
- R7: `word_vld_o` is high for exactly four cycles per refill. While it is low, `word_data_o` and `word_idx_o` are 0.
- R8: A request held high is taken again at the first idle edge after the done cycle, so exactly one non-busy cycle separates two refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Refill request, sampled while idle |
| blk_addr_i | input | BLK_AW | Block address, taken with the request |
| busy_o | output | 1 | Refill in progress |
| word_vld_o | output | 1 | A returned word is on the bus |
| word_idx_o | output | 2 | Index of the word on the bus (0 when no word) |
| word_data_o | output | DATA_W | Returned word (0 when no word) |
| done_o | output | 1 | One-cycle end-of-refill pulse |

## Verification
A controller stuck in the wrong state or a bank counter off by one shows at the ports within the same refill. Every output is compared each cycle against a timeline computed from the two latency formulas. A wrong latency therefore moves the first valid word, and a wrong word counter breaks the index order or the done cycle. A wrong bank or row selection shows on the very first word as a data value that does not match the address pattern. A request wrongly taken while busy shows as a restarted timeline or a changed address within a cycle or two.

// File: rtl/ilv_refill_pkg.sv
package ilv_refill_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACCESS,
        ST_XFER,
        ST_DONE
    } fetch_state_e;

    // Fixed storage pattern of word address waddr
    function automatic logic [31:0] fill_word(input logic [31:0] waddr);
        return (waddr * 32'h0001_0001) ^ 32'hC3C3_0000;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 6,
    parameter int LAT       = 15,
    parameter int NUM_BANKS = 4,
    parameter int BANK_ID   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic              fin_o,
    output logic [DATA_W-1:0] data_o
);
    import ilv_refill_pkg::*;

    localparam int DEPTH = 1 << ROW_W;
    localparam int CNT_W = $clog2(LAT + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic              active;
    logic [ROW_W-1:0]  row_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++) begin
                mem[r] <= DATA_W'(fill_word(32'(r * NUM_BANKS + BANK_ID)));
            end
            cnt    <= '0;
            active <= 1'b0;
            row_q  <= '0;
            data_q <= '0;
        end else if (start_i) begin
            active <= 1'b1;
            cnt    <= CNT_W'(LAT - 1);
            row_q  <= row_i;
        end else if (active) begin
            if (cnt == '0) begin
                active <= 1'b0;
                data_q <= mem[row_q];
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign fin_o  = active && (cnt == '0);
    assign data_o = data_q;

endmodule

// File: rtl/ilv_fsm.sv
module ilv_fsm #(
    parameter int INTERLEAVE = 1,
    parameter int NUM_BANKS  = 4,
    parameter int IDX_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 fin_i,
    output logic                 accept_o,
    output logic [NUM_BANKS-1:0] start_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic                 busy_o,
    output logic                 vld_o,
    output logic                 done_o
);
    import ilv_refill_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BANKS - 1);

    fetch_state_e     state, nxt_state;
    logic [IDX_W-1:0] idx, nxt_idx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt_state;
            idx   <= nxt_idx;
        end
    end

    // Transitions
    always_comb begin
        nxt_state = state;
        nxt_idx   = idx;
        unique case (state)
            ST_IDLE: begin
                nxt_idx = '0;
                if (req_i) nxt_state = ST_ADDR;
            end
            ST_ADDR:   nxt_state = ST_ACCESS;
            ST_ACCESS: if (fin_i) nxt_state = ST_XFER;
            ST_XFER: begin
                if (idx == LAST) begin
                    nxt_state = ST_DONE;
                end else begin
                    nxt_idx   = idx + 1'b1;
                    nxt_state = (INTERLEAVE != 0) ? ST_XFER : ST_ACCESS;
                end
            end
            ST_DONE: begin
                nxt_idx   = '0;
                nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept_o = (state == ST_IDLE) && req_i;
        busy_o   = (state != ST_IDLE);
        vld_o    = (state == ST_XFER);
        done_o   = (state == ST_DONE);
        for (int b = 0; b < NUM_BANKS; b++) begin
            start_o[b] = ((state == ST_ADDR) && ((INTERLEAVE != 0) || (b == 0)))
                      || ((INTERLEAVE == 0) && (state == ST_XFER) && (idx != LAST)
                          && (int'(idx) + 1 == b));
        end
    end

    assign idx_o = idx;

endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl #(
    parameter int DATA_W     = 32,
    parameter int BLK_AW     = 6,
    parameter int LAT        = 15,
    parameter int NUM_BANKS  = 4,
    parameter int INTERLEAVE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [BLK_AW-1:0] blk_addr_i,
    output logic              busy_o,
    output logic              word_vld_o,
    output logic [1:0]        word_idx_o,
    output logic [DATA_W-1:0] word_data_o,
    output logic              done_o
);
    localparam int IDX_W = $clog2(NUM_BANKS);

    logic                 accept;
    logic [NUM_BANKS-1:0] start;
    logic [NUM_BANKS-1:0] fin;
    logic [IDX_W-1:0]     idx;
    logic                 vld;
    logic [BLK_AW-1:0]    row_q;
    logic [DATA_W-1:0]    bank_data [NUM_BANKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      row_q <= '0;
        else if (accept) row_q <= blk_addr_i;
    end

    ilv_fsm #(
        .INTERLEAVE (INTERLEAVE),
        .NUM_BANKS  (NUM_BANKS),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .fin_i    (|fin),
        .accept_o (accept),
        .start_o  (start),
        .idx_o    (idx),
        .busy_o   (busy_o),
        .vld_o    (vld),
        .done_o   (done_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .DATA_W    (DATA_W),
            .ROW_W     (BLK_AW),
            .LAT       (LAT),
            .NUM_BANKS (NUM_BANKS),
            .BANK_ID   (b)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start[b]),
            .row_i   (row_q),
            .fin_o   (fin[b]),
            .data_o  (bank_data[b])
        );
    end

    assign word_vld_o  = vld;
    assign word_idx_o  = vld ? 2'(idx) : 2'd0;
    assign word_data_o = vld ? bank_data[idx] : '0;

endmodule

// File: rtl/ilv_refill_chk.sv
module ilv_refill_chk #(
    parameter int DATA_W     = 32,
    parameter int LAT        = 15,
    parameter int NUM_BANKS  = 4,
    parameter int INTERLEAVE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              busy_o,
    input logic              word_vld_o,
    input logic [1:0]        word_idx_o,
    input logic [DATA_W-1:0] word_data_o,
    input logic              done_o
);
    localparam int DONE_T = (INTERLEAVE != 0) ? (1 + LAT + NUM_BANKS)
                                              : (1 + NUM_BANKS * (LAT + 1));

    int busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_cnt <= 0;
        else if (!busy_o) busy_cnt <= 0;
        else              busy_cnt <= busy_cnt + 1;
    end

    // R3 and R4: done cycle sits at the formula for the chosen timing
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == DONE_T));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> busy_o);

    p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    p_done_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(word_vld_o) && ($past(word_idx_o) == 2'd3)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    p_vld_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> (busy_o && !done_o));

    p_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> ((word_data_o == '0) && (word_idx_o == 2'd0)));

    if (INTERLEAVE != 0) begin : g_ovl
        p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (word_vld_o && (word_idx_o != 2'd3)) |=>
                (word_vld_o && (word_idx_o == $past(word_idx_o) + 2'd1)));
    end else begin : g_ser
        p_idx_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            word_vld_o |=> !word_vld_o);
    end

endmodule

bind ilv_refill_ctrl ilv_refill_chk #(
    .DATA_W     (DATA_W),
    .LAT        (LAT),
    .NUM_BANKS  (NUM_BANKS),
    .INTERLEAVE (INTERLEAVE)
) u_chk (.*);

// File: tb/ilv_refill_ctrl_tb_top.sv
module ilv_refill_ctrl_tb_top;
    localparam int LAT = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [5:0] addr = '0;
    always #5 clk = ~clk;

    logic busy_a, vld_a, done_a, busy_b, vld_b, done_b;
    logic [1:0] idx_a, idx_b;
    logic [31:0] data_a, data_b;

    ilv_refill_ctrl #(.LAT(LAT), .INTERLEAVE(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .blk_addr_i(addr),
        .busy_o(busy_a), .word_vld_o(vld_a), .word_idx_o(idx_a),
        .word_data_o(data_a), .done_o(done_a));

    ilv_refill_ctrl #(.LAT(LAT), .INTERLEAVE(0)) dut_s (
        .clk(clk), .rst_n(rst_n), .req_i(req), .blk_addr_i(addr),
        .busy_o(busy_b), .word_vld_o(vld_b), .word_idx_o(idx_b),
        .word_data_o(data_b), .done_o(done_b));

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit comparing = 0;
    bit finished = 0;

    // Behavioural model: cycles since acceptance (-1 = idle) and taken address
    int mt_i = -1, mt_s = -1;
    int ma_i = 0, ma_s = 0;

    function automatic int done_t(bit ilv);
        return ilv ? (1 + LAT + 4) : (1 + 4 * (LAT + 1));
    endfunction

    function automatic int word_at(int t, bit ilv);
        for (int k = 0; k < 4; k++) begin
            if (t == (ilv ? (1 + LAT + k) : (1 + LAT + k * (LAT + 1)))) return k;
        end
        return -1;
    endfunction

    function automatic logic [31:0] pattern(int a, int k);
        logic [31:0] w;
        w = 32'(4 * a + k);
        return (w * 32'h0001_0001) ^ 32'hC3C3_0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mt_i <= -1; mt_s <= -1;
        end else begin
            if (mt_i < 0) begin
                if (req) begin mt_i <= 0; ma_i <= int'(addr); end
            end else if (mt_i == done_t(1)) mt_i <= -1;
            else mt_i <= mt_i + 1;
            if (mt_s < 0) begin
                if (req) begin mt_s <= 0; ma_s <= int'(addr); end
            end else if (mt_s == done_t(0)) mt_s <= -1;
            else mt_s <= mt_s + 1;
        end
    end

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic compare(input bit ilv, input int mt, input int ma,
                           input logic b, input logic v, input logic [1:0] ix,
                           input logic [31:0] d, input logic dn);
        int k;
        k = (mt >= 0) ? word_at(mt, ilv) : -1;
        check("R2", ilv ? "busy ovl" : "busy ser", longint'(b), longint'(mt >= 0));
        check(ilv ? "R3" : "R4", "word valid", longint'(v), longint'(k >= 0));
        check(k >= 0 ? "R5" : "R7", "word index", longint'(ix), longint'(k >= 0 ? k : 0));
        check(k >= 0 ? "R5" : "R7", "word data", longint'(d),
              longint'(k >= 0 ? pattern(ma, k) : 32'd0));
        check("R6", "done", longint'(dn), longint'(mt == done_t(ilv)));
        if (v && ix == 2'd3)
            check(ilv ? "R3" : "R4", "last word cycle", longint'(mt),
                  longint'(ilv ? (1 + LAT + 3) : (1 + LAT + 3 * (LAT + 1))));
    endtask

    always @(negedge clk) begin
        if (comparing) begin
            compare(1'b1, mt_i, ma_i, busy_a, vld_a, idx_a, data_a, done_a);
            compare(1'b0, mt_s, ma_s, busy_b, vld_b, idx_b, data_b, done_b);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 40000 && !finished) begin
            bad++;
            $display("FAIL R2 watchdog: act=hung exp=idle");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic issue(input int a);
        @(negedge clk);
        req = 1'b1; addr = 6'(a);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_idle();
        while (mt_i >= 0 || mt_s >= 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset held
        check("R1", "busy in reset", longint'(busy_a | busy_b), 0);
        check("R1", "data in reset", longint'(data_a | data_b), 0);
        rst_n = 1'b1;
        comparing = 1;
        @(negedge clk);
        check("R1", "valid after reset", longint'(vld_a | vld_b | done_a | done_b), 0);
        check("R1", "index after reset", longint'(idx_a | idx_b), 0);

        issue(5);   wait_idle();
        issue(63);  wait_idle();
        issue(0);   wait_idle();

        // R2: request during busy is ignored
        issue(10);
        repeat (4) @(negedge clk);
        req = 1'b1; addr = 6'd20;
        @(negedge clk);
        req = 1'b0; addr = 6'd0;
        wait_idle();

        // R8: request held high across refills
        @(negedge clk);
        req = 1'b1; addr = 6'd33;
        while (!done_a) @(negedge clk);
        @(negedge clk);
        check("R8", "idle gap after done", longint'(busy_a), 0);
        @(negedge clk);
        check("R8", "retaken at first idle edge", longint'(busy_a), 1);
        repeat (60) @(negedge clk);
        req = 1'b0;
        wait_idle();

        for (int a = 1; a < 64; a += 13) begin
            issue(a);
            wait_idle();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule